// File: doc/BRIEF.md
# PWM Pair Generator with Edge Delays and Safe-State Trip

This block drives two pulse-width-modulated outputs from a free-running up-counter. A configuration port lets the controlling logic set the period, two compare thresholds, an operating mode, the rise-to-rise and fall-to-fall guard times, and the behaviour of a protective trip. In independent mode each output has its own compare threshold. In complementary mode the second output is the inverse of the first, and guard times are inserted so that the two outputs are never high together.

A dedicated trip input pulls both outputs low in the same cycle it goes high. The trip can be sticky, so that the outputs stay low until a clear is written, or it can clear itself at the next period boundary once the input has gone away. Period and compare writes go into shadow copies and reach the counter logic only when the counter wraps, so a waveform never sees a torn update in the middle of a period.

Register map (cfg_addr): 0 period, 1 compare A, 2 compare B, 3 mode (bit 0 = complementary, bit 1 = self-clearing trip), 4 guard times (bits 7:0 = delay on the rising edge of pwm_a, bits 15:8 = delay on the rising edge of pwm_b), 5 trip clear (the data is ignored).

Top module: `pwm_deadband_gen`

## Requirements
- R1: The count runs 0,1,…,P and then returns to 0, where P is the active period. period_pulse is high for exactly the cycles in which the count equals P.
- R2: A count value C in one cycle makes the undelayed A waveform high in the next cycle if and only if C is less than the active compare A. A compare of 0 keeps A low, and a compare above P keeps A high.
- R3: In independent mode (mode bit 0 = 0), pwm_b follows the same rule as pwm_a but uses compare B, and no guard delay is applied to either output.
- R4: In complementary mode (mode bit 0 = 1), the undelayed B waveform is the inverse of the undelayed A waveform, and pwm_a and pwm_b are never high in the same cycle.
- R5: In complementary mode, pwm_a goes high only after its undelayed waveform has been high for rise delay + 1 consecutive samples, and it goes low in the same cycle as that waveform. A delay of 0 adds no cycles. A high pulse no longer than the delay never reaches the output.
- R6: In complementary mode, the rising edge of pwm_b (which is the falling edge of A) is delayed in the same way by the fall delay, using bits 15:8 of the guard register.
- R7: Writes to the period and compare registers take effect at the first wrap after the write. The values in use stay unchanged between wraps.
- R8: While trip_in is high, both outputs are low in that same cycle.
- R9: In sticky trip mode (mode bit 1 = 0), a trip keeps both outputs low until a write to address 5 in a cycle where trip_in is low. Period wraps do not release it.
- R10: In self-clearing mode (mode bit 1 = 1), the trip is released at the first wrap with trip_in low.
- R11: After reset both outputs are low and every register is zero. With a zero period, period_pulse is therefore high in every cycle until a period is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | CNT_W | Configuration write data |
| trip_in | input | 1 | External trip request, active high |
| pwm_a | output | 1 | First PWM output |
| pwm_b | output | 1 | Second PWM output |
| period_pulse | output | 1 | High while the count equals the period |

## Verification
The bench sweeps compare A across every value from 0 to one past the period. A design that compares with <= or mishandles the ends would show an extra high cycle, or a fully high or fully low output in the wrong place. It runs every pair of rise and fall delays from 0 to 3, along with pulses shorter than the delay. An off-by-one delay counter, or one that lets a short pulse through, changes the edge positions of the waveform. It writes new period and compare values in the middle of a period, so a design without shadowing changes the waveform before the wrap. Sticky and self-clearing trips are exercised across several wraps: a sticky trip that releases on a wrap, or a self-clearing trip that stays asserted, is caught in the first period after the trip.

// File: rtl/pwm_dbt_pkg.sv
package pwm_dbt_pkg;

    typedef enum logic [2:0] {
        SEL_PERIOD = 3'd0,
        SEL_CMPA   = 3'd1,
        SEL_CMPB   = 3'd2,
        SEL_MODE   = 3'd3,
        SEL_GUARD  = 3'd4,
        SEL_TRCLR  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic cbc;    // 1: trip self-clears at wrap
        logic compl;  // 1: complementary pair
    } mode_t;

    localparam int NUM_CH = 2;

    function automatic logic sel_hit(input logic we, input logic [2:0] addr, input reg_sel_e sel);
        return we && (reg_sel_e'(addr) == sel);
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_dbt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] prd_sh,
    output logic [CNT_W-1:0] cmpa_sh,
    output logic [CNT_W-1:0] cmpb_sh,
    output mode_t            mode,
    output logic [DLY_W-1:0] rise_dly,
    output logic [DLY_W-1:0] fall_dly,
    output logic             trip_clr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prd_sh   <= '0;
            cmpa_sh  <= '0;
            cmpb_sh  <= '0;
            mode     <= '0;
            rise_dly <= '0;
            fall_dly <= '0;
        end else begin
            if (sel_hit(we, addr, SEL_PERIOD)) prd_sh  <= wdata;
            if (sel_hit(we, addr, SEL_CMPA))   cmpa_sh <= wdata;
            if (sel_hit(we, addr, SEL_CMPB))   cmpb_sh <= wdata;
            if (sel_hit(we, addr, SEL_MODE))   mode    <= mode_t'(wdata[1:0]);
            if (sel_hit(we, addr, SEL_GUARD)) begin
                rise_dly <= wdata[DLY_W-1:0];
                fall_dly <= wdata[2*DLY_W-1:DLY_W];
            end
        end
    end

    assign trip_clr = sel_hit(we, addr, SEL_TRCLR);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] prd_sh,
    input  logic [CNT_W-1:0] cmpa_sh,
    input  logic [CNT_W-1:0] cmpb_sh,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmpa_act,
    output logic [CNT_W-1:0] cmpb_act,
    output logic             wrap
);
    logic [CNT_W-1:0] prd_act;

    assign wrap = (cnt == prd_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            prd_act  <= '0;
            cmpa_act <= '0;
            cmpb_act <= '0;
        end else if (wrap) begin
            cnt      <= '0;
            prd_act  <= prd_sh;
            cmpa_act <= cmpa_sh;
            cmpb_act <= cmpb_sh;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_edge_delay.sv
module pwm_edge_delay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_in,
    input  logic [DLY_W-1:0] dly,
    output logic             sig_out
);
    localparam logic [DLY_W-1:0] RUN_MAX = '1;

    logic [DLY_W-1:0] run_q;  // consecutive high samples seen so far

    always_ff @(posedge clk) begin
        if (rst || !sig_in) begin
            run_q   <= '0;
            sig_out <= 1'b0;
        end else begin
            sig_out <= (run_q >= dly);
            if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_trip.sv
module pwm_trip (
    input  logic clk,
    input  logic rst,
    input  logic trip_in,
    input  logic cbc,
    input  logic clr_wr,
    input  logic wrap,
    output logic trip_flag,
    output logic force_low
);
    always_ff @(posedge clk) begin
        if (rst)                          trip_flag <= 1'b0;
        else if (trip_in)                 trip_flag <= 1'b1;
        else if (clr_wr || (cbc && wrap)) trip_flag <= 1'b0;
    end

    assign force_low = trip_in | trip_flag;
endmodule

// File: rtl/pwm_deadband_gen.sv
module pwm_deadband_gen
    import pwm_dbt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             trip_in,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic             period_pulse
);
    logic [CNT_W-1:0] prd_sh, cmpa_sh, cmpb_sh;
    logic [CNT_W-1:0] cnt, cmpa_act, cmpb_act;
    logic [DLY_W-1:0] rise_dly, fall_dly;
    mode_t            mode;
    logic             trip_clr, wrap, trip_flag, force_low;
    logic             in_a, in_b;

    logic [NUM_CH-1:0] ch_in;
    logic [NUM_CH-1:0] ch_out;
    logic [DLY_W-1:0]  ch_dly [NUM_CH];

    pwm_regs #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .prd_sh(prd_sh), .cmpa_sh(cmpa_sh), .cmpb_sh(cmpb_sh), .mode(mode),
        .rise_dly(rise_dly), .fall_dly(fall_dly), .trip_clr(trip_clr)
    );

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst(rst), .prd_sh(prd_sh), .cmpa_sh(cmpa_sh), .cmpb_sh(cmpb_sh),
        .cnt(cnt), .cmpa_act(cmpa_act), .cmpb_act(cmpb_act), .wrap(wrap)
    );

    assign in_a = (cnt < cmpa_act);
    assign in_b = mode.compl ? ~in_a : (cnt < cmpb_act);

    assign ch_in     = {in_b, in_a};
    assign ch_dly[0] = mode.compl ? rise_dly : '0;
    assign ch_dly[1] = mode.compl ? fall_dly : '0;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_edge_delay #(.DLY_W(DLY_W)) u_dly (
            .clk(clk), .rst(rst), .sig_in(ch_in[g]), .dly(ch_dly[g]), .sig_out(ch_out[g])
        );
    end

    pwm_trip u_trip (
        .clk(clk), .rst(rst), .trip_in(trip_in), .cbc(mode.cbc), .clr_wr(trip_clr),
        .wrap(wrap), .trip_flag(trip_flag), .force_low(force_low)
    );

    assign pwm_a        = ch_out[0] & ~force_low;
    assign pwm_b        = ch_out[1] & ~force_low;
    assign period_pulse = wrap;
endmodule

// File: rtl/pwm_deadband_gen_chk.sv
module pwm_deadband_gen_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             trip_in,
    input logic             pwm_a,
    input logic             pwm_b,
    input logic             period_pulse,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmpa_act,
    input logic             in_a,
    input logic             compl,
    input logic             cbc,
    input logic             trip_flag,
    input logic             clr_wr
);
    assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (rst)
        period_pulse |=> (cnt == '0));

    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        !period_pulse |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        $past(compl) |-> !(pwm_a && pwm_b));

    assert_a_needs_input_R5: assert property (@(posedge clk) disable iff (rst)
        pwm_a |-> $past(in_a));

    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !period_pulse |=> $stable(cmpa_act));

    assert_trip_forces_low_R8: assert property (@(posedge clk) disable iff (rst)
        trip_in |-> (!pwm_a && !pwm_b));

    assert_latched_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (trip_flag && !cbc && !clr_wr) |=> trip_flag);

    assert_cbc_release_R10: assert property (@(posedge clk) disable iff (rst)
        (cbc && period_pulse && !trip_in) |=> !trip_flag);
endmodule

bind pwm_deadband_gen pwm_deadband_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .trip_in(trip_in), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .period_pulse(period_pulse), .cnt(cnt), .cmpa_act(cmpa_act), .in_a(in_a),
    .compl(mode.compl), .cbc(mode.cbc), .trip_flag(trip_flag), .clr_wr(trip_clr)
);

// File: tb/pwm_deadband_gen_bench.sv
module pwm_deadband_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        trip_in = 1'b0;
    logic        pwm_a, pwm_b, period_pulse;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    pwm_deadband_gen u_pwm_deadband_gen (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .trip_in(trip_in), .pwm_a(pwm_a), .pwm_b(pwm_b), .period_pulse(period_pulse)
    );

    // Reference model built from the requirements
    logic [15:0] m_cnt, m_prd, m_prd_sh, m_ca, m_ca_sh, m_cb, m_cb_sh;
    logic        m_compl, m_cbc, m_flag, e_a, e_b;
    logic [7:0]  m_rise, m_fall;
    logic [31:0] h_a, h_b;
    string       tag_a = "R2", tag_b = "R3", tag_p = "R1";

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_cnt = '0; m_prd = '0; m_prd_sh = '0; m_ca = '0; m_ca_sh = '0; m_cb = '0; m_cb_sh = '0;
        m_compl = 1'b0; m_cbc = 1'b0; m_flag = 1'b0; e_a = 1'b0; e_b = 1'b0;
        m_rise = '0; m_fall = '0; h_a = '0; h_b = '0;
    endtask

    // Called just after a falling edge; leaves just after the next falling edge.
    task automatic step(input logic we, input logic [2:0] addr, input logic [15:0] data, input logic trip);
        logic        wrap, ia, ib;
        logic [31:0] mk_a, mk_b;
        cfg_we = we; cfg_addr = addr; cfg_wdata = data; trip_in = trip;
        #1;
        check(tag_p, "period_pulse", period_pulse, m_cnt == m_prd);
        check(tag_a, "pwm_a", pwm_a, e_a & ~(trip | m_flag));
        check(tag_b, "pwm_b", pwm_b, e_b & ~(trip | m_flag));
        @(posedge clk);
        wrap = (m_cnt == m_prd);
        ia   = (m_cnt < m_ca);
        ib   = m_compl ? !ia : (m_cnt < m_cb);
        h_a  = {h_a[30:0], ia};
        h_b  = {h_b[30:0], ib};
        mk_a = (32'h1 << ((m_compl ? 32'(m_rise) : 32'd0) + 1)) - 32'h1;
        mk_b = (32'h1 << ((m_compl ? 32'(m_fall) : 32'd0) + 1)) - 32'h1;
        e_a  = ((h_a & mk_a) == mk_a);
        e_b  = ((h_b & mk_b) == mk_b);
        if (trip) m_flag = 1'b1;
        else if ((we && addr == 3'd5) || (m_cbc && wrap)) m_flag = 1'b0;
        if (wrap) begin
            m_cnt = '0; m_prd = m_prd_sh; m_ca = m_ca_sh; m_cb = m_cb_sh;
        end else begin
            m_cnt = m_cnt + 16'd1;
        end
        if (we) begin
            case (addr)
                3'd0: m_prd_sh = data;
                3'd1: m_ca_sh  = data;
                3'd2: m_cb_sh  = data;
                3'd3: begin m_compl = data[0]; m_cbc = data[1]; end
                3'd4: begin m_rise = data[7:0]; m_fall = data[15:8]; end
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic run(input int n, input logic trip);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 16'd0, trip);
    endtask

    task automatic wr(input logic [2:0] addr, input logic [15:0] data);
        step(1'b1, addr, data, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1; cfg_we = 1'b0; trip_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
        #1;
        // R11: reset state
        check("R11", "pwm_a after reset", pwm_a, 1'b0);
        check("R11", "pwm_b after reset", pwm_b, 1'b0);
        check("R11", "period_pulse after reset", period_pulse, 1'b1);
    endtask

    task automatic setup(input logic [15:0] prd, input logic [15:0] ca, input logic [15:0] cb,
                         input logic [7:0] rise, input logic [7:0] fall, input logic [1:0] md);
        do_reset();
        wr(3'd0, prd); wr(3'd1, ca); wr(3'd2, cb);
        wr(3'd4, {fall, rise}); wr(3'd3, {14'd0, md});
    endtask

    initial begin
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 R2 R3: independent channels
        tag_p = "R1"; tag_a = "R2"; tag_b = "R3";
        setup(16'd9, 16'd4, 16'd7, 8'd5, 8'd5, 2'b00);
        run(30, 1'b0);

        // R2 R3: compare sweep across the whole range incl. 0 and above period
        for (int c = 0; c <= 7; c++) begin
            setup(16'd5, 16'(c), 16'(7 - c), 8'd0, 8'd0, 2'b00);
            run(16, 1'b0);
        end

        // R4 R5 R6: complementary with every small guard pair
        for (int r = 0; r < 4; r++) begin
            for (int f = 0; f < 4; f++) begin
                tag_a = (r == 0 && f == 0) ? "R4" : "R5";
                tag_b = (r == 0 && f == 0) ? "R4" : "R6";
                setup(16'd11, 16'd6, 16'd0, 8'(r), 8'(f), 2'b01);
                run(30, 1'b0);
            end
        end

        // R5: high pulse shorter than rise delay is swallowed
        tag_a = "R5"; tag_b = "R6";
        setup(16'd11, 16'd2, 16'd0, 8'd4, 8'd0, 2'b01);
        run(30, 1'b0);
        // R6: low pulse of A shorter than fall delay never raises B
        setup(16'd11, 16'd10, 16'd0, 8'd0, 8'd3, 2'b01);
        run(30, 1'b0);

        // R7: mid-period writes wait for the wrap
        tag_p = "R7"; tag_a = "R7"; tag_b = "R7";
        setup(16'd9, 16'd3, 16'd8, 8'd0, 8'd0, 2'b00);
        run(13, 1'b0);
        wr(3'd1, 16'd7); wr(3'd0, 16'd6); wr(3'd2, 16'd2);
        run(30, 1'b0);

        // R8 R9: sticky trip
        tag_p = "R1"; tag_a = "R8"; tag_b = "R8";
        setup(16'd7, 16'd4, 16'd0, 8'd1, 8'd1, 2'b01);
        run(10, 1'b0);
        run(1, 1'b1);
        tag_a = "R9"; tag_b = "R9";
        run(25, 1'b0);
        wr(3'd5, 16'h0000);
        run(20, 1'b0);

        // R8 R10: self-clearing trip, short and held
        tag_a = "R8"; tag_b = "R8";
        setup(16'd7, 16'd4, 16'd0, 8'd1, 8'd1, 2'b11);
        run(11, 1'b0);
        run(2, 1'b1);
        tag_a = "R10"; tag_b = "R10";
        run(25, 1'b0);
        tag_a = "R8"; tag_b = "R8";
        run(12, 1'b1);
        tag_a = "R10"; tag_b = "R10";
        run(20, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule